// File: doc/BRIEF.md
# Late-Write Pipelined Synchronous SRAM

This block is a single-port synchronous memory built so that reads and writes can follow each other in any order without an idle bus cycle. Each operation begins with one command registration. A read hands its word to an output register one enabled edge later. A write takes its data two enabled edges after the command. Because of this, the write data occupies the same bus slot a read's output would use, and the shared bus never needs a gap to change direction.

The data bus is split into separate ports: an input word, an output word and an output-drive enable. A clock enable can freeze the whole pipeline. Three chip selects gate the start of an operation. A load/advance input either starts a new operation at the external address or repeats the previous operation at the next address of a linear burst. A read of a word whose write data is still in flight returns the in-flight lanes.

Top module: `nowait_sram`

## Requirements
- R1: An operation loads only on an enabled edge (`clk_en_n` low) with `load_n` low and all three selects active (`sel1_n`=0, `sel2`=1, `sel3_n`=0). It is a read when `wr_n`=1 and a write when `wr_n`=0.
- R2: For a read registered at enabled edge k, `rdata` carries the word after enabled edge k+1, and `rdata_oe` is high while `out_en_n` is low.
- R3: For a write registered at enabled edge k, the word on `wdata` at enabled edge k+2 is written to the command's address.
- R4: While `clk_en_n` is high, every synchronous input is ignored and every register holds its value, including `rdata`, `rdata_oe` and pending writes. Late write data is taken on the second enabled edge after the command.
- R5: `lane_wr_n[i]` is active low and guards bits [8i+7:8i]. A write with every lane bit high is an abort that leaves the array unchanged.
- R6: An edge with `load_n` low and any select inactive is a deselect. An edge with `load_n` high after a deselect is also a deselect. Neither writes anything, and `rdata_oe` is low after the following edge.
- R7: `out_en_n` gates `rdata_oe` combinationally. A read issued with `out_en_n` high is a dummy read with the bus undriven, and lowering `out_en_n` later drives the held word at once without a clock edge.
- R8: With `load_n` high after a read or a write, the same operation continues. The two low address bits count up by one and wrap inside their group of four, and a continued write takes new lane enables each beat.
- R9: A read whose address matches a write that commits on the same edge the read data is registered returns the new data in the enabled lanes and the array data in the other lanes.
- R10: Reset (`rst_n` low, synchronous) drops every pending write and leaves `rdata_oe` low.
- R11: A read and a write may alternate on consecutive edges with no idle cycle, and each returns or stores its own word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_en_n | input | 1 | Clock enable, active low; high freezes the block |
| sel1_n | input | 1 | Select 1, active low |
| sel2 | input | 1 | Select 2, active high |
| sel3_n | input | 1 | Select 3, active low |
| load_n | input | 1 | Low loads a new operation, high continues the burst |
| wr_n | input | 1 | Low for write, high for read (taken when loading) |
| lane_wr_n | input | LANES | Per-lane write enables, active low |
| out_en_n | input | 1 | Asynchronous output-drive enable, active low |
| addr | input | ADDR_W | Word address |
| wdata | input | LANES*LANE_W | Write data, sampled two enabled edges after the command |
| rdata | output | LANES*LANE_W | Read data from the output register |
| rdata_oe | output | 1 | Drive enable for `rdata` on the shared bus |

## Verification
The bench uses the default parameters: 64 words of four 8-bit lanes and a 2-bit burst field. With these values, every lane enable pattern, including the all-high abort, can be written out as a literal. A burst that starts at offsets 1 and 2 of its group wraps within four beats. The word width is small enough that lane-merged bypass results can be stated as constants in the checks.

// File: rtl/nowait_sram_pkg.sv
// Shared types for the late-write SRAM.
// Assumes: nothing beyond IEEE 1800-2017.
package nowait_sram_pkg;
    // Kind of operation held in the command stage.
    typedef enum logic [1:0] {
        OPK_NONE  = 2'd0,
        OPK_READ  = 2'd1,
        OPK_WRITE = 2'd2
    } op_kind_t;
endpackage

// File: rtl/nowait_sram_cmd.sv
// Command stage: decodes load/continue/deselect and holds the current
// operation kind, address and lane enables. Continuation steps the low
// BURST_W address bits by one with wrap-around.
// Assumes: en is the decoded clock enable; sel is the combined select.
module nowait_sram_cmd
    import nowait_sram_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int LANES   = 4,
    parameter int BURST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              load_n,
    input  logic              sel,
    input  logic              wr_n,
    input  logic [LANES-1:0]  lane_wr_n,
    input  logic [ADDR_W-1:0] addr,
    output op_kind_t          kind,
    output logic [ADDR_W-1:0] op_addr,
    output logic [LANES-1:0]  op_lane_n
);
    localparam int HI_W = ADDR_W - BURST_W;

    logic [ADDR_W-1:0] step_addr;

    // Next address in the burst: low field increments and wraps.
    always_comb begin
        step_addr = {op_addr[ADDR_W-1:BURST_W], op_addr[BURST_W-1:0] + BURST_W'(1)};
    end

    // Register the command on each enabled edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind      <= OPK_NONE;
            op_addr   <= '0;
            op_lane_n <= '1;
        end else if (en) begin
            if (!load_n) begin
                if (sel) begin
                    kind      <= wr_n ? OPK_READ : OPK_WRITE;
                    op_addr   <= addr;
                    op_lane_n <= lane_wr_n;
                end else begin
                    kind      <= OPK_NONE;
                    op_lane_n <= '1;
                end
            end else if (kind != OPK_NONE) begin
                op_addr   <= step_addr;
                op_lane_n <= lane_wr_n;
            end
        end
    end

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(kind) && $stable(op_addr) && $stable(op_lane_n))); // R4
    AST_DESELECT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !load_n && !sel) |=> (kind == OPK_NONE)); // R6
    AST_DESELECT_CONT: assert property (@(posedge clk) disable iff (!rst_n)
        (en && load_n && kind == OPK_NONE) |=> (kind == OPK_NONE)); // R6
    AST_BURST_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && load_n && kind != OPK_NONE) |=>
        (op_addr[ADDR_W-1:BURST_W] == $past(op_addr[ADDR_W-1:BURST_W]) &&
         kind == $past(kind))); // R8

    logic [HI_W-1:0] unused_hi;
    assign unused_hi = step_addr[ADDR_W-1:BURST_W];
endmodule

// File: rtl/nowait_sram_wpipe.sv
// Late-write stage: carries a write command one enabled edge further, so
// that it commits together with its data on the second enabled edge.
// Aborted writes (all lanes off) are dropped here.
// Assumes: kind/op_addr/op_lane_n come from the command stage.
module nowait_sram_wpipe
    import nowait_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  op_kind_t          kind,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [LANES-1:0]  op_lane_n,
    output logic              late_vld,
    output logic [ADDR_W-1:0] late_addr,
    output logic [LANES-1:0]  late_lane_n
);
    // Advance the pending write on each enabled edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            late_vld    <= 1'b0;
            late_addr   <= '0;
            late_lane_n <= '1;
        end else if (en) begin
            late_vld    <= (kind == OPK_WRITE) && !(&op_lane_n);
            late_addr   <= op_addr;
            late_lane_n <= op_lane_n;
        end
    end

    AST_LATE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (en && kind == OPK_WRITE && !(&op_lane_n)) |=> late_vld); // R3
    AST_ABORT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (en && kind == OPK_WRITE && (&op_lane_n)) |=> !late_vld); // R5
endmodule

// File: rtl/nowait_sram_array.sv
// Storage array in byte lanes with one write port and one combinational
// read port. A read of the address being written in the same cycle sees
// the new data in the written lanes.
// Assumes: contents are not reset.
module nowait_sram_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [LANES-1:0]        wr_lane_n,
    input  logic [LANES*LANE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [LANES*LANE_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];
        logic              hit;

        // Write this lane when enabled for the committing write.
        always_ff @(posedge clk) begin
            if (wr_en && !wr_lane_n[g]) begin
                cells[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
            end
        end

        // Forward same-cycle write data on an address match.
        always_comb begin
            hit = wr_en && !wr_lane_n[g] && (wr_addr == rd_addr);
            rd_data[g*LANE_W +: LANE_W] = hit ? wr_data[g*LANE_W +: LANE_W]
                                              : cells[rd_addr];
        end
    end
endmodule

// File: rtl/nowait_sram.sv
// Top of the late-write pipelined SRAM. Command stage, late-write stage,
// lane array and the read output register. Reads return one enabled edge
// after the command; writes commit two enabled edges after it.
// Assumes: out_en_n is asynchronous and only gates the drive enable.
module nowait_sram
    import nowait_sram_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int LANES   = 4,
    parameter int LANE_W  = 8,
    parameter int BURST_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clk_en_n,
    input  logic                    sel1_n,
    input  logic                    sel2,
    input  logic                    sel3_n,
    input  logic                    load_n,
    input  logic                    wr_n,
    input  logic [LANES-1:0]        lane_wr_n,
    input  logic                    out_en_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rdata_oe
);
    localparam int DATA_W = LANES * LANE_W;

    logic              en;
    logic              sel;
    op_kind_t          kind;
    logic [ADDR_W-1:0] op_addr;
    logic [LANES-1:0]  op_lane_n;
    logic              late_vld;
    logic [ADDR_W-1:0] late_addr;
    logic [LANES-1:0]  late_lane_n;
    logic              commit;
    logic [DATA_W-1:0] arr_q;
    logic [DATA_W-1:0] out_q;
    logic              out_vld;

    // Decode clock enable, combined select and the commit strobe.
    always_comb begin
        en     = !clk_en_n;
        sel    = !sel1_n && sel2 && !sel3_n;
        commit = en && late_vld;
    end

    nowait_sram_cmd #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES),
        .BURST_W(BURST_W)
    ) u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .load_n   (load_n),
        .sel      (sel),
        .wr_n     (wr_n),
        .lane_wr_n(lane_wr_n),
        .addr     (addr),
        .kind     (kind),
        .op_addr  (op_addr),
        .op_lane_n(op_lane_n)
    );

    nowait_sram_wpipe #(
        .ADDR_W(ADDR_W),
        .LANES (LANES)
    ) u_wpipe (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .kind       (kind),
        .op_addr    (op_addr),
        .op_lane_n  (op_lane_n),
        .late_vld   (late_vld),
        .late_addr  (late_addr),
        .late_lane_n(late_lane_n)
    );

    nowait_sram_array #(
        .ADDR_W(ADDR_W),
        .LANES (LANES),
        .LANE_W(LANE_W)
    ) u_array (
        .clk      (clk),
        .wr_en    (commit),
        .wr_addr  (late_addr),
        .wr_lane_n(late_lane_n),
        .wr_data  (wdata),
        .rd_addr  (op_addr),
        .rd_data  (arr_q)
    );

    // Output register: capture read data one enabled edge after the command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld <= 1'b0;
            out_q   <= '0;
        end else if (en) begin
            out_vld <= (kind == OPK_READ);
            if (kind == OPK_READ) begin
                out_q <= arr_q;
            end
        end
    end

    // Bus drive: asynchronous gate by out_en_n.
    always_comb begin
        rdata    = out_q;
        rdata_oe = out_vld && !out_en_n;
    end

    AST_OE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_n |-> !rdata_oe); // R7
    AST_READ_NEXT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (en && kind == OPK_READ) |=> out_vld); // R2
    AST_NONREAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (en && kind != OPK_READ) |=> !rdata_oe); // R6
    AST_COMMIT_NEEDS_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !(&late_lane_n)); // R5
endmodule

// File: tb/nowait_sram_tb.sv
// Directed bench for nowait_sram. Inputs change at the falling edge;
// outputs are sampled at the falling edge after the relevant rising edge.
module nowait_sram_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clk_en_n = 1'b0;
    logic        sel1_n = 1'b1;
    logic        sel2 = 1'b1;
    logic        sel3_n = 1'b0;
    logic        load_n = 1'b0;
    logic        wr_n = 1'b1;
    logic [3:0]  lane_wr_n = 4'hF;
    logic        out_en_n = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rdata_oe;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    nowait_sram u_dut (
        .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .sel1_n(sel1_n),
        .sel2(sel2), .sel3_n(sel3_n), .load_n(load_n), .wr_n(wr_n),
        .lane_wr_n(lane_wr_n), .out_en_n(out_en_n), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic cen, input logic ld, input logic s1n, input logic s2,
                         input logic s3n, input logic wn, input logic [3:0] ln,
                         input logic [5:0] a, input logic [31:0] d);
        clk_en_n = cen; load_n = ld; sel1_n = s1n; sel2 = s2; sel3_n = s3n;
        wr_n = wn; lane_wr_n = ln; addr = a; wdata = d;
        @(negedge clk);
    endtask

    task automatic rd(input logic [5:0] a, input logic [31:0] d);
        drive(0, 0, 0, 1, 0, 1, 4'hF, a, d);
    endtask
    task automatic wr(input logic [5:0] a, input logic [3:0] ln, input logic [31:0] d);
        drive(0, 0, 0, 1, 0, 0, ln, a, d);
    endtask
    task automatic cont(input logic [3:0] ln, input logic [31:0] d);
        drive(0, 1, 0, 1, 0, 1, ln, 6'd0, d);
    endtask
    task automatic desel(input logic [31:0] d);
        drive(0, 0, 1, 1, 0, 1, 4'hF, 6'd0, d);
    endtask
    task automatic stall(input logic [31:0] d);
        drive(1, 0, 0, 1, 0, 0, 4'h0, 6'd31, d);
    endtask
    task automatic write1(input logic [5:0] a, input logic [3:0] ln, input logic [31:0] d);
        wr(a, ln, 0); desel(0); desel(d);
    endtask
    task automatic read1(input string req, input logic [5:0] a, input logic [31:0] exp);
        rd(a, 0); desel(0);
        chk(req, rdata, exp);
        chk(req, {31'd0, rdata_oe}, 32'd1);
    endtask

    // R2 R3: plain write then read back.
    task automatic t_basic();
        write1(3, 4'h0, 32'hD3D3_0003);
        read1("R2", 3, 32'hD3D3_0003);
        write1(31, 4'h0, 32'h3131_3131);
        read1("R3", 31, 32'h3131_3131);
    endtask

    // R11: read and write alternate on consecutive edges.
    task automatic t_interleave();
        wr(10, 4'h0, 0);
        rd(3, 0);
        wr(11, 4'h0, 32'h1010_1010);
        chk("R11 read slot", rdata, 32'hD3D3_0003);
        chk("R11 read drive", {31'd0, rdata_oe}, 32'd1);
        rd(10, 0);
        chk("R11 write slot undriven", {31'd0, rdata_oe}, 32'd0);
        desel(32'h1111_1111);
        chk("R11 first write", rdata, 32'h1010_1010);
        read1("R11 second write", 11, 32'h1111_1111);
    endtask

    // R5: lane enables and abort.
    task automatic t_lanes();
        write1(12, 4'h0, 32'h1122_3344);
        write1(12, 4'b1010, 32'hAABB_CCDD);
        write1(12, 4'hF, 32'hFFFF_FFFF);
        read1("R5", 12, 32'h11BB_33DD);
    endtask

    // R9: read right behind a write to the same address.
    task automatic t_bypass();
        wr(21, 4'h0, 0); rd(21, 0); desel(32'h2121_ABCD);
        chk("R9 full", rdata, 32'h2121_ABCD);
        write1(20, 4'h0, 32'h0102_0304);
        wr(20, 4'b0011, 0); rd(20, 0); desel(32'hA0B0_C0D0);
        chk("R9 merge", rdata, 32'hA0B0_0304);
    endtask

    // R4: stall holds output and postpones late data.
    task automatic t_stall();
        rd(3, 0); desel(0);
        stall(32'hDEAD_BEEF); stall(32'hDEAD_BEEF);
        chk("R4 hold data", rdata, 32'hD3D3_0003);
        chk("R4 hold drive", {31'd0, rdata_oe}, 32'd1);
        wr(30, 4'h0, 0);
        stall(32'hBAD0_0000); stall(32'hBAD0_0001);
        desel(32'hBAD0_0002); desel(32'h3030_3030);
        read1("R4 late data", 30, 32'h3030_3030);
        read1("R4 ignored inputs", 31, 32'h3131_3131);
    endtask

    // R1 R6: each inactive select blocks the operation.
    task automatic t_deselect();
        write1(40, 4'h0, 32'h4040_4040);
        for (int v = 0; v < 3; v++) begin
            drive(0, 0, v == 0, v != 1, v == 2, 0, 4'h0, 6'd40, 0);
            drive(0, 1, 0, 1, 0, 0, 4'h0, 6'd40, 0);
            desel(32'hEEEE_0000); desel(32'hEEEE_0001);
        end
        read1("R6 no write", 40, 32'h4040_4040);
        drive(0, 0, 1, 1, 0, 1, 4'hF, 6'd3, 0);
        desel(0);
        chk("R1 read deselected", {31'd0, rdata_oe}, 32'd0);
        drive(0, 0, 0, 0, 0, 1, 4'hF, 6'd3, 0);
        cont(4'hF, 0);
        chk("R6 continue deselect", {31'd0, rdata_oe}, 32'd0);
    endtask

    // R7: dummy read and asynchronous output enable.
    task automatic t_oe();
        out_en_n = 1'b1;
        rd(3, 0); desel(0);
        chk("R7 dummy read", {31'd0, rdata_oe}, 32'd0);
        out_en_n = 1'b0; #1;
        chk("R7 async on", {31'd0, rdata_oe}, 32'd1);
        chk("R7 held data", rdata, 32'hD3D3_0003);
        out_en_n = 1'b1; #1;
        chk("R7 async off", {31'd0, rdata_oe}, 32'd0);
        out_en_n = 1'b0;
    endtask

    // R8: linear bursts wrap in a group of four.
    task automatic t_burst();
        wr(6, 4'h0, 0); cont(4'h0, 0); cont(4'h0, 32'hB000_0006);
        cont(4'h0, 32'hB000_0007); desel(32'hB000_0004); desel(32'hB000_0005);
        rd(5, 0);
        cont(4'hF, 0); chk("R8 beat0", rdata, 32'hB000_0005);
        cont(4'hF, 0); chk("R8 beat1", rdata, 32'hB000_0006);
        cont(4'hF, 0); chk("R8 beat2", rdata, 32'hB000_0007);
        desel(0);      chk("R8 wrap", rdata, 32'hB000_0004);
    endtask

    // R10: reset drops a pending write and disables the output.
    task automatic t_reset();
        write1(50, 4'h0, 32'h5050_5050);
        rd(3, 0);
        wr(50, 4'h0, 0);
        rst_n = 1'b0;
        desel(32'h0BAD_0BAD); desel(32'h0BAD_0BAD);
        rst_n = 1'b1;
        chk("R10 output off", {31'd0, rdata_oe}, 32'd0);
        read1("R10 write dropped", 50, 32'h5050_5050);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        @(negedge clk); @(negedge clk); @(negedge clk);
        chk("R10 reset state", {31'd0, rdata_oe}, 32'd0);
        rst_n = 1'b1;
        desel(0);
        t_basic();
        t_interleave();
        t_lanes();
        t_bypass();
        t_stall();
        t_deselect();
        t_oe();
        t_burst();
        t_reset();
        finish_run();
    end
endmodule